// File: doc/BRIEF.md
# Serial audio receive port with clock generation

The block takes serial PCM audio from an external converter and turns it into parallel samples. A frame clock marks the channel: low is the left sample and high is the right sample. Each bit of data is taken on a rising edge of the bit clock. The most significant bit comes one bit clock after each frame clock transition. Finished samples are right-aligned into 24 bits and placed in a small FIFO. A downstream consumer reads the FIFO through a valid/ready handshake.

The clocks come from one of two places. When the port is the clock master, it divides its system clock to make the bit clock and the frame clock, and it drives both outward. When the port is the clock slave, it takes both clocks from outside. They can come from its own pins, or from a peer instance of the same port that is acting as master, in which case the two share one sample rate. Selecting the transmit direction always makes the port master. The same synchronizer and edge detector handle both clocking modes, so there is only one receive path. All configuration comes from static inputs.

Top module: `aud_rx_port`

## Requirements
- R1: In master mode `bclk_out` stays high for max(`cfg_div`,2) system clocks and then low for the same number. `fclk_out` toggles only on a falling edge of `bclk_out`, once every H bit clocks. `clk_drive` is high.
- R2: `cfg_ratio` sets the number of bit clocks per frame, which is 2*H: 0 gives 32 (H=16), 1 gives 48 (H=24), and 2 or 3 give 64 (H=32).
- R3: `cfg_tx_dir`=1 makes the port the clock master even when `cfg_master`=0.
- R4: In slave mode both clocks come from outside through a two-stage synchronizer. `bclk_out`, `fclk_out` and `clk_drive` stay low. The system clock must run at least 4 times faster than the bit clock.
- R5: In slave mode `cfg_use_peer`=1 takes the clocks from `peer_bclk`/`peer_fclk` and ignores the pin clocks. With 0 it takes them from `pin_bclk`/`pin_fclk`.
- R6: Data is sampled on rising bit clock edges, MSB first, starting one bit clock after a frame clock transition. `rd_right` is 0 for a left word (frame clock low) and 1 for a right word (frame clock high).
- R7: The sample width is `cfg_width`, clamped to 16..24. Bits sent after that width in a half frame are ignored. The word is right-aligned in `rd_data`, and the bits above the width are zero. When the width equals H, the LSB is taken on the first rising edge after the next transition.
- R8: After `cfg_enable` rises, reception begins only at the first falling edge of the frame clock, so the first stored word is a left word.
- R9: The FIFO returns words in arrival order. It holds `FIFO_DEPTH` (4) words. While `rd_valid`=1 and `rd_ready`=0, `rd_data` and `rd_right` stay stable.
- R10: A word that completes while the FIFO is full is dropped, and `ovf_flag` is set. The flag stays set until `ovf_clear` is pulsed. If both happen in the same cycle, setting wins.
- R11: While `cfg_enable`=0 no words are stored and the master clocks are stopped. Words already in the FIFO can still be read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Port enable |
| cfg_master | input | 1 | 1 = clock master for receive |
| cfg_tx_dir | input | 1 | Transmit direction selected (forces master) |
| cfg_use_peer | input | 1 | Slave clock source: 1 = peer instance, 0 = pins |
| cfg_ratio | input | 2 | Bit clocks per frame: 0 = 32, 1 = 48, 2 or 3 = 64 |
| cfg_width | input | 5 | Sample width, clamped to 16..24 |
| cfg_div | input | DIV_W | Bit clock half period in system clocks (minimum 2) |
| pin_bclk | input | 1 | Bit clock from pin (slave) |
| pin_fclk | input | 1 | Frame clock from pin (slave) |
| peer_bclk | input | 1 | Bit clock from peer master |
| peer_fclk | input | 1 | Frame clock from peer master |
| sdata | input | 1 | Serial data in |
| bclk_out | output | 1 | Generated bit clock |
| fclk_out | output | 1 | Generated frame clock |
| clk_drive | output | 1 | High when the port drives its clock pins |
| rd_valid | output | 1 | FIFO head valid |
| rd_ready | input | 1 | Consumer accepts head |
| rd_data | output | 24 | Right-aligned sample |
| rd_right | output | 1 | 1 = right channel sample |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_clear | input | 1 | Clears the overflow flag |

## Verification
The bench plays the converter. It loads a random word at each frame transition and shifts it out on falling bit clock edges. It fills the bits after the configured width with random junk, so any capture that runs past the width would corrupt the result. Runs in master mode, including the one forced by the transmit direction, check the generated periods. Slave runs are fed from the pins and then from the peer inputs while the other source carries noise, which shows whether the source select works. Widths equal to H and smaller than H separate the case where the LSB spills into the next half frame from the case where trailing bits must be dropped. Random ready patterns and a run with the consumer held off separate the handshake hold behaviour from drop-on-full with the sticky flag. Further random configurations are mixed in.

// File: rtl/aud_pkg.sv
package aud_pkg;
  localparam int SAMPLE_MAX = 24;
  localparam int WORD_W     = SAMPLE_MAX + 1;

  // bit clocks per half frame for a ratio code
  function automatic logic [5:0] half_slots(input logic [1:0] ratio);
    case (ratio)
      2'd0:    half_slots = 6'd16;
      2'd1:    half_slots = 6'd24;
      default: half_slots = 6'd32;
    endcase
  endfunction

  // sample width clamped to the supported range
  function automatic logic [4:0] eff_width(input logic [4:0] w);
    if (w < 5'd16)      eff_width = 5'd16;
    else if (w > 5'd24) eff_width = 5'd24;
    else                eff_width = w;
  endfunction
endpackage

// File: rtl/aud_clk_gen.sv
module aud_clk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       cfg_ratio,
  input  logic [DIV_W-1:0] cfg_div,
  output logic             bclk,
  output logic             fclk
);
  import aud_pkg::*;

  logic [DIV_W-1:0] cnt;
  logic [5:0]       slot;
  logic [DIV_W-1:0] div_eff;
  logic [5:0]       hlim;

  assign div_eff = (cfg_div < DIV_W'(2)) ? DIV_W'(2) : cfg_div;
  assign hlim    = half_slots(cfg_ratio);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; slot <= '0; bclk <= 1'b0; fclk <= 1'b1;
    end else if (!run) begin
      cnt <= '0; slot <= '0; bclk <= 1'b0; fclk <= 1'b1;
    end else if (cnt == div_eff - DIV_W'(1)) begin
      cnt  <= '0;
      bclk <= ~bclk;
      if (bclk) begin
        if (slot == hlim - 6'd1) begin
          slot <= '0;
          fclk <= ~fclk;
        end else begin
          slot <= slot + 6'd1;
        end
      end
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/aud_sync.sv
module aud_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/aud_rx_deser.sv
module aud_rx_deser (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        bclk_s,
  input  logic        fclk_s,
  input  logic        sd_s,
  input  logic [4:0]  cfg_width,
  output logic        word_done,
  output logic [23:0] word_data,
  output logic        word_right,
  output logic        first_word
);
  import aud_pkg::*;

  logic        bclk_d, seen, fclk_last, started, collecting, chan;
  logic [4:0]  cnt, width, cnt_nx;
  logic [23:0] sh, shift_nx;
  logic        rise, take, chg, begin_word;

  assign width      = eff_width(cfg_width);
  assign rise       = en & bclk_s & ~bclk_d;
  assign take       = rise & collecting;
  assign cnt_nx     = cnt + 5'd1;
  assign shift_nx   = {sh[22:0], sd_s};
  assign word_done  = take && (cnt_nx == width);
  assign chg        = rise && seen && (fclk_s != fclk_last);
  assign begin_word = chg && (started || !fclk_s);
  assign word_data  = shift_nx;
  assign word_right = chan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_d <= 1'b0;
    else        bclk_d <= bclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0; fclk_last <= 1'b0; started <= 1'b0; collecting <= 1'b0;
      chan <= 1'b0; cnt <= '0; sh <= '0; first_word <= 1'b0;
    end else if (!en) begin
      seen <= 1'b0; started <= 1'b0; collecting <= 1'b0; first_word <= 1'b0;
    end else if (rise) begin
      seen      <= 1'b1;
      fclk_last <= fclk_s;
      if (take) begin
        sh  <= shift_nx;
        cnt <= cnt_nx;
      end
      if (word_done) begin
        collecting <= 1'b0;
        first_word <= 1'b0;
      end
      if (begin_word) begin
        sh         <= '0;
        cnt        <= '0;
        collecting <= 1'b1;
        chan       <= fclk_s;
        started    <= 1'b1;
        if (!started) first_word <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/aud_fifo.sv
module aud_fifo #(
  parameter int DW    = 25,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          full,
  output logic          empty,
  output logic [DW-1:0] head
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = mem[rp];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    bump = (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/aud_rx_port.sv
module aud_rx_port #(
  parameter int DIV_W      = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_master,
  input  logic             cfg_tx_dir,
  input  logic             cfg_use_peer,
  input  logic [1:0]       cfg_ratio,
  input  logic [4:0]       cfg_width,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             pin_bclk,
  input  logic             pin_fclk,
  input  logic             peer_bclk,
  input  logic             peer_fclk,
  input  logic             sdata,
  output logic             bclk_out,
  output logic             fclk_out,
  output logic             clk_drive,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [23:0]      rd_data,
  output logic             rd_right,
  output logic             ovf_flag,
  input  logic             ovf_clear
);
  import aud_pkg::*;

  logic master_run, gen_bclk, gen_fclk;
  logic src_bclk, src_fclk;
  logic bclk_s, fclk_s, sd_s;
  logic word_done, word_right, first_word;
  logic [23:0] word_data;
  logic fifo_full, fifo_empty;
  logic [WORD_W-1:0] fifo_head;

  assign master_run = cfg_enable & (cfg_master | cfg_tx_dir);

  aud_clk_gen #(.DIV_W(DIV_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .run(master_run), .cfg_ratio(cfg_ratio),
    .cfg_div(cfg_div), .bclk(gen_bclk), .fclk(gen_fclk)
  );

  always_comb begin
    if (master_run)        begin src_bclk = gen_bclk;  src_fclk = gen_fclk;  end
    else if (cfg_use_peer) begin src_bclk = peer_bclk; src_fclk = peer_fclk; end
    else                   begin src_bclk = pin_bclk;  src_fclk = pin_fclk;  end
  end

  aud_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({src_bclk, src_fclk, sdata}),
    .q({bclk_s, fclk_s, sd_s})
  );

  aud_rx_deser u_deser (
    .clk(clk), .rst_n(rst_n), .en(cfg_enable), .bclk_s(bclk_s), .fclk_s(fclk_s),
    .sd_s(sd_s), .cfg_width(cfg_width), .word_done(word_done),
    .word_data(word_data), .word_right(word_right), .first_word(first_word)
  );

  aud_fifo #(.DW(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(word_done), .push_data({word_right, word_data}),
    .pop(rd_ready), .full(fifo_full), .empty(fifo_empty), .head(fifo_head)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ovf_flag <= 1'b0;
    else if (word_done && fifo_full) ovf_flag <= 1'b1;
    else if (ovf_clear)              ovf_flag <= 1'b0;
  end

  assign bclk_out  = gen_bclk;
  assign fclk_out  = master_run & gen_fclk;
  assign clk_drive = master_run;
  assign rd_valid  = ~fifo_empty;
  assign rd_data   = fifo_head[23:0];
  assign rd_right  = fifo_head[24];
endmodule

// File: rtl/aud_rx_port_chk.sv
module aud_rx_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        master_run,
  input logic        bclk_out,
  input logic        fclk_out,
  input logic        word_done,
  input logic        word_right,
  input logic        first_word,
  input logic        fifo_full,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [23:0] rd_data,
  input logic        rd_right,
  input logic        ovf_flag,
  input logic        ovf_clear
);
  AST_FCLK_ON_BCLK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (master_run && $past(master_run) && (fclk_out != $past(fclk_out))) |-> $fell(bclk_out)); // R1

  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !master_run |-> (!bclk_out && !fclk_out)); // R4

  AST_FIRST_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && first_word) |-> !word_right); // R8

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_right))); // R9

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && fifo_full) |=> ovf_flag); // R10

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clear) |=> ovf_flag); // R10
endmodule

bind aud_rx_port aud_rx_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .master_run(master_run), .bclk_out(bclk_out),
  .fclk_out(fclk_out), .word_done(word_done), .word_right(word_right),
  .first_word(first_word), .fifo_full(fifo_full), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_data(rd_data), .rd_right(rd_right),
  .ovf_flag(ovf_flag), .ovf_clear(ovf_clear)
);

// File: tb/aud_rx_port_tb.sv
`timescale 1ns/1ps
module aud_rx_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable = 0, cfg_master = 0, cfg_tx_dir = 0, cfg_use_peer = 0;
  logic [1:0] cfg_ratio = 0;
  logic [4:0] cfg_width = 16;
  logic [7:0] cfg_div = 2;
  logic pin_bclk = 0, pin_fclk = 0, peer_bclk = 0, peer_fclk = 0, sdata = 0;
  logic bclk_out, fclk_out, clk_drive, rd_valid, rd_right, ovf_flag;
  logic rd_ready = 0, ovf_clear = 0;
  logic [23:0] rd_data;

  always #2.5 clk = ~clk;

  aud_rx_port u_dut (.*);

  int total = 0, bad = 0, cyc = 0;
  int got = 0;
  int rdy_mode = 0;            // 0 always, 1 random, 2 never
  logic [24:0] expq[$];

  // bench model of the configuration
  function automatic int h_of(input logic [1:0] r);
    return (r == 2'd0) ? 16 : (r == 2'd1) ? 24 : 32;
  endfunction
  function automatic int w_of(input logic [4:0] w);
    return (w < 16) ? 16 : (w > 24) ? 24 : int'(w);
  endfunction

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // slave clock generator and converter model
  logic sg_on = 0, sg_b = 0, sg_f = 1, prev_b = 0, cod_fl = 1, bstart = 0;
  int sg_cnt = 0, sg_slot = 0, txcnt = 0;
  logic [23:0] txsh = 0;
  localparam int SG_HP = 3;

  always @(negedge clk) begin
    logic ab, af, mst;
    logic [23:0] wd;
    mst = cfg_enable & (cfg_master | cfg_tx_dir);
    if (sg_on) begin
      sg_cnt++;
      if (sg_cnt == SG_HP) begin
        sg_cnt = 0;
        sg_b = ~sg_b;
        if (!sg_b) begin
          sg_slot++;
          if (sg_slot == h_of(cfg_ratio)) begin sg_slot = 0; sg_f = ~sg_f; end
        end
      end
    end
    if (cfg_use_peer) begin
      peer_bclk = sg_b; peer_fclk = sg_f;
      pin_bclk = 1'($urandom); pin_fclk = 1'($urandom);
    end else begin
      pin_bclk = sg_b; pin_fclk = sg_f;
      peer_bclk = 1'($urandom); peer_fclk = 1'($urandom);
    end
    ab = mst ? bclk_out : sg_b;
    af = mst ? fclk_out : sg_f;
    if (prev_b && !ab) begin
      if (txcnt > 0) begin
        sdata = txsh[23]; txsh = txsh << 1; txcnt--;
      end else sdata = 1'($urandom);
      if (af != cod_fl) begin
        wd = 24'($urandom) & 24'((1 << w_of(cfg_width)) - 1);
        txsh = wd << (24 - w_of(cfg_width));
        txcnt = w_of(cfg_width);
        if (!af) bstart = 1;
        if (bstart) expq.push_back({af, wd});
        cod_fl = af;
      end
    end
    prev_b = ab;
  end

  // consumer
  always @(negedge clk) begin
    logic r;
    logic [24:0] e;
    r = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? 1'($urandom) : 1'b0;
    rd_ready = r;
    if (r && rd_valid) begin
      if (expq.size() == 0) chk(1'b0, "R9 unexpected word", {rd_right, rd_data}, 0);
      else begin
        e = expq.pop_front();
        if (got == 0) chk(rd_right == 1'b0, "R8 first word left", rd_right, 0);
        chk({rd_right, rd_data} == e, "R6/R7 word", {rd_right, rd_data}, e);
      end
      got++;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      chk(1'b0, "watchdog", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic setup(input logic m, input logic tx, input logic peer, input logic [1:0] ra,
                       input logic [4:0] w, input logic [7:0] dv, input int rm);
    @(negedge clk);
    rst_n = 0; cfg_enable = 0;
    cfg_master = m; cfg_tx_dir = tx; cfg_use_peer = peer;
    cfg_ratio = ra; cfg_width = w; cfg_div = dv; rdy_mode = rm;
    sg_on = 0; sg_b = 0; sg_f = 1; sg_cnt = 0; sg_slot = 0;
    prev_b = 0; cod_fl = 1; bstart = 0; txcnt = 0; got = 0;
    expq.delete();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cfg_enable = 1;
    sg_on = !(m | tx);
  endtask

  task automatic wait_words(input int n);
    while (got < n) @(negedge clk);
  endtask

  task automatic check_master_timing(input int dv, input logic [1:0] ra, input string tag);
    int n;
    int de;
    de = (dv < 2) ? 2 : dv;
    while (bclk_out != 0) @(negedge clk);
    while (bclk_out != 1) @(negedge clk);
    n = 0;
    while (bclk_out == 1) begin n++; @(negedge clk); end
    chk(n == de, {tag, " bclk half period"}, n, de);
    begin
      logic f0;
      f0 = fclk_out;
      while (fclk_out == f0) @(negedge clk);
      f0 = fclk_out; n = 0;
      while (fclk_out == f0) begin n++; @(negedge clk); end
      chk(n == 2 * de * h_of(ra), {tag, " fclk half frame (R2)"}, n, 2 * de * h_of(ra));
    end
    chk(clk_drive == 1, {tag, " clk_drive"}, clk_drive, 1);
  endtask

  initial begin
    // reset state
    repeat (2) @(negedge clk);
    chk(rd_valid == 0, "R9 reset rd_valid", rd_valid, 0);
    chk(ovf_flag == 0, "R10 reset ovf", ovf_flag, 0);
    chk(bclk_out == 0 && clk_drive == 0, "R11 reset clocks idle", {bclk_out, clk_drive}, 0);

    // R1 R2: master 32x, width 16
    setup(1, 0, 0, 2'd0, 5'd16, 8'd3, 0);
    check_master_timing(3, 2'd0, "R1");
    wait_words(10);
    chk(got >= 10, "R1 master words", got, 10);

    // R3: tx direction forces master, ratio code 3 means 64x, width 24
    setup(0, 1, 0, 2'd3, 5'd24, 8'd1, 1);
    check_master_timing(1, 2'd3, "R3");
    wait_words(8);

    // R4: slave from pins, 48x, width 24 (LSB in next half frame)
    setup(0, 0, 0, 2'd1, 5'd24, 8'd2, 1);
    repeat (20) @(negedge clk);
    chk(clk_drive == 0 && bclk_out == 0 && fclk_out == 0, "R4 slave outputs quiet",
        {clk_drive, bclk_out, fclk_out}, 0);
    wait_words(8);

    // R5 R7: peer source, 64x, width 16, junk after width; pins carry noise
    setup(0, 0, 1, 2'd2, 5'd16, 8'd2, 0);
    wait_words(8);
    chk(got >= 8, "R5 peer source words", got, 8);

    // R7: width above range clamps to 24
    setup(1, 0, 0, 2'd2, 5'd30, 8'd2, 1);
    wait_words(6);

    // R10 R11: overflow with consumer held off
    setup(1, 0, 0, 2'd1, 5'd20, 8'd2, 2);
    while (!ovf_flag) @(negedge clk);
    chk(ovf_flag == 1 && rd_valid == 1, "R10 overflow set", {ovf_flag, rd_valid}, 2'b11);
    cfg_enable = 0;
    repeat (40) @(negedge clk);
    chk(bclk_out == 0 && clk_drive == 0, "R11 disabled clocks stop", {bclk_out, clk_drive}, 0);
    rdy_mode = 1;
    wait_words(4);
    repeat (10) @(negedge clk);
    chk(rd_valid == 0 && got == 4, "R9 depth four kept", got, 4);
    chk(ovf_flag == 1, "R10 ovf sticky", ovf_flag, 1);
    ovf_clear = 1;
    @(negedge clk);
    ovf_clear = 0;
    @(negedge clk);
    chk(ovf_flag == 0, "R10 ovf cleared", ovf_flag, 0);

    // random configurations
    void'($urandom(32'h5A17));
    for (int i = 0; i < 5; i++) begin
      logic [1:0] ra;
      logic m;
      ra = 2'($urandom % 3);
      m = 1'($urandom);
      setup(m, 0, 1'($urandom), ra,
            (ra == 0) ? 5'd16 : 5'(16 + $urandom % 9),
            8'(2 + $urandom % 3), 1);
      wait_words(6);
      chk(got >= 6, "R6 random config words", got, 6);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule